// File: doc/BRIEF.md
# Sequential Shift-and-Add Unsigned Multiplier

This block forms the exact unsigned product of two N-bit operands over N clock cycles. A one-cycle `start` pulse latches both operands. On each following cycle the block inspects one bit of the multiplier operand, starting with the least significant. When that bit is one, it adds the multiplicand into the upper half of a 2N-bit accumulator. The accumulator then moves one position to the right. After N such steps the accumulator holds the product, and `done` pulses for one cycle.

Every accumulation goes through a carry-select adder that settles its whole carry word before it forms the sum. The adder computes a half-sum and a half-carry word, then derives two carry words in parallel, one for carry-in zero and one for carry-in one. It picks one of them with AND-OR logic and only then XORs the result into the final sum. The top-bit carry-out of that adder becomes the new accumulator MSB, so no carry is lost. The default width is 16 bits.

Top module: `shift_add_mul`

## Requirements
- R1: `product` equals the exact unsigned product `multiplicand * multiplier` of the operands latched by the accepted start, both read as unsigned N-bit values and the result read as an unsigned 2N-bit value.
- R2: `done` is high during exactly one cycle, and that cycle is the one that follows the N-th rising edge after the edge that accepted `start`.
- R3: From the cycle in which `done` is high until the edge that accepts the next start, `product` does not change.
- R4: A `start` seen while a multiplication is in progress has no effect: the running operation keeps its operands, its result and its `done` timing.
- R5: A synchronous active-high `rst` clears `done` to 0 and `product` to 0, and leaves the block idle so that the next `start` is accepted.
- R6: A multiplier operand of zero gives a zero product, and all-ones times all-ones gives (2^N-1)^2 with no lost carry.
- R7: Each accumulation step adds the upper N accumulator bits to the gated multiplicand in a carry-select adder whose {carry-out, sum} equals their exact (N+1)-bit sum.
- R8: A `start` that arrives in the same cycle as `done` is accepted, and it begins a new multiplication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a multiplication (ignored while busy) |
| multiplicand | input | N | Unsigned multiplicand, sampled with an accepted start |
| multiplier | input | N | Unsigned multiplier, sampled with an accepted start |
| product | output | 2N | Accumulator; final product once done has pulsed |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can land in the same cycle: the completion pulse of one multiplication and the acceptance of the next `start`. The bench provokes this by raising `start` with fresh operands in exactly the cycle where its reference model predicts `done`. It then expects the old product in that cycle, a reload at the next edge, and a second pulse N cycles later carrying the new product. A related case puts a `start` in the middle of a busy window. There, the reference model must show that the finishing cycle and the result are unchanged.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } mul_ctrl_t;
endpackage

// File: rtl/csel_adder.sv
module csel_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W-1:0] halfSum, halfCarry, carryZero, carryOne, carrySel;

  assign halfSum   = a ^ b;
  assign halfCarry = a & b;

  assign carryZero[0] = halfCarry[0];
  assign carryOne[0]  = halfCarry[0] | halfSum[0];

  genvar i;
  generate
    for (i = 1; i < W; i++) begin : g_carry
      assign carryZero[i] = halfCarry[i] | (halfSum[i] & carryZero[i-1]);
      assign carryOne[i]  = halfCarry[i] | (halfSum[i] & carryOne[i-1]);
    end
  endgenerate

  // carryOne dominates carryZero, so selection reduces to AND-OR
  assign carrySel = carryZero | ({W{cin}} & carryOne);

  assign sum[0] = halfSum[0] ^ cin;
  generate
    if (W > 1) begin : g_sum
      assign sum[W-1:1] = halfSum[W-1:1] ^ carrySel[W-2:0];
    end
  endgenerate
  assign cout = carrySel[W-1];
endmodule

// File: rtl/mul_control.sv
module mul_control
  import mul_pkg::*;
#(
  parameter int N = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  output mul_ctrl_t ctrl,
  output logic      done
);
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic          busy;
  logic [CW-1:0] stepCnt;

  assign ctrl.load = start && !busy;
  assign ctrl.step = busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ctrl.load) begin
        busy    <= 1'b1;
        stepCnt <= '0;
      end else if (busy) begin
        stepCnt <= stepCnt + 1'b1;
        if (stepCnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R2: completion only ever follows a busy cycle
  p_done_follows_busy_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));
  // R2: single-cycle pulse
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R4: a start during the busy window does not cut the run short
  p_ignore_start_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && start && stepCnt != LAST) |=> busy);
  // R5: reset leaves the controller idle
  p_reset_idle_r5: assert property (@(posedge clk)
    rst |=> (!busy && !done));
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath
  import mul_pkg::*;
#(
  parameter int N = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  mul_ctrl_t      ctrl,
  input  logic [N-1:0]   mcandIn,
  input  logic [N-1:0]   mplierIn,
  output logic [2*N-1:0] acc
);
  localparam int PW = 2 * N;

  logic [N-1:0] mcandReg;
  logic [N-1:0] addend;
  logic [N-1:0] upperSum;
  logic         upperCarry;

  assign addend = acc[0] ? mcandReg : '0;

  csel_adder #(.W(N)) u_add (
    .a    (acc[PW-1:N]),
    .b    (addend),
    .cin  (1'b0),
    .sum  (upperSum),
    .cout (upperCarry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      mcandReg <= '0;
    end else if (ctrl.load) begin
      acc      <= {{N{1'b0}}, mplierIn};
      mcandReg <= mcandIn;
    end else if (ctrl.step) begin
      acc <= {upperCarry, upperSum, acc[N-1:1]};
    end
  end

  // R7: adder result matches exact arithmetic on every accumulation step
  p_adder_exact_r7: assert property (@(posedge clk) disable iff (rst)
    ctrl.step |-> ({upperCarry, upperSum} ==
                   ((N+1)'(acc[PW-1:N]) + (N+1)'(addend))));
  // R3: accumulator holds when neither loading nor stepping
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.load && !ctrl.step) |=> $stable(acc));
  // R5: reset clears the accumulator
  p_reset_clear_r5: assert property (@(posedge clk)
    rst |=> (acc == '0));
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul
  import mul_pkg::*;
#(
  parameter int N = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [N-1:0]   multiplicand,
  input  logic [N-1:0]   multiplier,
  output logic [2*N-1:0] product,
  output logic           done
);
  mul_ctrl_t ctrl;

  mul_control #(.N(N)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .ctrl  (ctrl),
    .done  (done)
  );

  mul_datapath #(.N(N)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .mcandIn  (multiplicand),
    .mplierIn (multiplier),
    .acc      (product)
  );
endmodule

// File: tb/sim_shift_add_mul.sv
`timescale 1ns/1ps
module sim_shift_add_mul;
  localparam int N = 16;
  localparam int PW = 2 * N;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [N-1:0]  multiplicand = '0;
  logic [N-1:0]  multiplier = '0;
  logic [PW-1:0] product;
  logic          done;

  int testsRun = 0;
  int testsFailed = 0;
  string curReq = "R5";

  always #4 clk = ~clk;

  shift_add_mul #(.N(N)) u0 (
    .clk(clk), .rst(rst), .start(start),
    .multiplicand(multiplicand), .multiplier(multiplier),
    .product(product), .done(done)
  );

  // behavioural reference
  bit            seen = 1'b0;
  bit            mBusy = 1'b0;
  bit            mDone = 1'b0;
  int            mCnt = 0;
  logic [PW-1:0] mA = '0, mB = '0, mProd = '0;

  always @(posedge clk) begin
    seen = 1'b1;
    if (rst) begin
      mBusy = 0; mDone = 0; mCnt = 0; mProd = '0;
    end else begin
      mDone = 0;
      if (mBusy) begin
        mCnt++;
        if (mCnt == N) begin
          mBusy = 0; mDone = 1; mProd = mA * mB;
        end
      end else if (start) begin
        mBusy = 1; mCnt = 0;
        mA = PW'(multiplicand); mB = PW'(multiplier);
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (seen) begin
      testsRun++;
      if (done !== mDone) begin
        testsFailed++;
        $display("FAIL R2 (%s) done: actual %0b expected %0b", curReq, done, mDone);
      end
      if (!mBusy) begin
        testsRun++;
        if (product !== mProd) begin
          testsFailed++;
          $display("FAIL %s product: actual %h expected %h",
                   mDone ? curReq : {curReq, "/R3"}, product, mProd);
        end
      end
    end
  end

  task automatic waitDone();
    while (!mDone) @(negedge clk);
  endtask

  task automatic runOp(input logic [N-1:0] a, input logic [N-1:0] b, input string req);
    @(negedge clk);
    curReq = req;
    start = 1'b1; multiplicand = a; multiplier = b;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    @(negedge clk);
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    // R5: reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    runOp(16'd3, 16'd5, "R1");
    runOp(16'h1234, 16'h00FF, "R1");
    runOp(16'hABCD, 16'h0000, "R6");
    runOp(16'h0000, 16'h8001, "R6");
    runOp(16'hFFFF, 16'hFFFF, "R6");
    runOp(16'hFFFF, 16'h7FFF, "R7");
    runOp(16'h8000, 16'hFFFF, "R7");
    runOp(16'h0001, 16'h8000, "R1");

    // R3: result held over idle cycles
    curReq = "R3";
    repeat (10) @(negedge clk);

    // R4: start pulse with other operands in the middle of a run
    @(negedge clk);
    curReq = "R4";
    start = 1'b1; multiplicand = 16'h0F0F; multiplier = 16'h3333;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    start = 1'b1; multiplicand = 16'hFFFF; multiplier = 16'hFFFF;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    @(negedge clk);

    // R8: new start in the same cycle as done
    @(negedge clk);
    curReq = "R8";
    start = 1'b1; multiplicand = 16'h1357; multiplier = 16'h2468;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    start = 1'b1; multiplicand = 16'hFEDC; multiplier = 16'hBA98;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    @(negedge clk);

    // R1: varied operand patterns
    for (int k = 0; k < 24; k++) begin
      runOp(N'($urandom), N'($urandom), "R1");
    end

    // R5: reset mid-run returns to a cleared, idle state
    @(negedge clk);
    curReq = "R5";
    start = 1'b1; multiplicand = 16'h5555; multiplier = 16'hAAAA;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    runOp(16'h00FF, 16'h0101, "R5");

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule